// File: doc/BRIEF.md
# Digest Engine Register Front-End

This block is the register interface that software uses to drive a message-digest engine supporting four algorithms. A 32-bit word-addressed bus reaches a small register set. Through it software can hold the engine in a soft reset, load the total message length in bits as a 64-bit quantity, and pick the algorithm and the input byte ordering. The same set holds interrupt status, enable and clear registers, four fixed identification words, and a result queue from which the finished digest is read one word per access.

The hash rounds live outside this block. A core delivers digest words one per cycle and then a completion pulse, and the queue accepts those words. The data write port also lives outside. It is told through `configured` that the engine is programmed, and it reports each data word it accepts on `dataWordSeen`. A data word that arrives before configuration is flagged as an error. Reading the queue when it is empty is also flagged as an error.

Top module: `digest_reg_frontend`

## Requirements
- R1: After `rstN` is released, every writable register, the interrupt status, the queue, `configured`, `engineReset`, `irq` and `busRdata` are zero.
- R2: Offsets 0x04 and 0x08 hold the upper and lower 32 bits of the message length in bits. Both read back as written, and `msgLenBits` equals {upper, lower}.
- R3: A write to the control register at 0x0C keeps bits [1:0] as the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and bits [9:8] as the byte order. Every other bit reads back as zero. The write sets `configured` unless the engine is held in soft reset.
- R4: Writing 1 to bit 0 of offset 0x00 raises `engineReset` and holds it until 0 is written. While it is held, `configured`, the queue and the interrupt status are cleared, and core words are not accepted. Length and enable registers keep their values.
- R5: Each read of offset 0x1C returns the oldest unread digest word and removes it, so words come out in the order the core delivered them. Up to QDEPTH words are held.
- R6: A read of 0x1C while the queue is empty returns zero and sets status bit 2. It leaves the queue consistent, so the next delivered word is the next one read.
- R7: A pulse on `dataWordSeen` while `configured` is low sets status bit 3. A pulse while `configured` is high does not.
- R8: Each accepted core word sets status bit 0, and a `coreDone` pulse sets status bit 1.
- R9: Writing a mask to offset 0x18 clears exactly the status bits [3:0] that are 1 in the mask. If a bit is set and cleared in the same cycle, the set wins.
- R10: `irq` is registered. It goes high one cycle after any status bit whose enable bit (offset 0x14, bits [3:0]) is 1 becomes set, and it stays high until those bits are cleared. Status bits that are not enabled never raise it.
- R11: Reading the status register at 0x10 returns bits [3:0] of the status. Bit 8 reads as 1 exactly when some enabled status bit is set.
- R12: Offsets 0x40, 0x50, 0x60 and 0x70 return the parameters ID_WORD0 to ID_WORD3, and writes to them change nothing. Unmapped offsets and the clear register read as zero.
- R13: `digestWords` gives the digest length in words for the selected algorithm: 4, 5, 7 and 8 for codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the read strobe |
| coreWordValid | input | 1 | Core presents a digest word |
| coreWord | input | 32 | Digest word from the core |
| coreDone | input | 1 | Core completion pulse |
| dataWordSeen | input | 1 | Data port accepted a message word |
| configured | output | 1 | Engine has been programmed since the last soft reset |
| engineReset | output | 1 | Soft reset held to the engine |
| cfgAlgo | output | 2 | Selected algorithm code |
| cfgByteOrder | output | 2 | Selected input byte order |
| msgLenBits | output | 64 | Message length in bits |
| digestWords | output | 4 | Digest length in words for the algorithm |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench runs the queue at every fill level from empty to full. It drains the queue and then makes one read too many. A pointer that slips on an empty read would return stale data, and the push that follows would come back misplaced. It sweeps all algorithm and byte-order codes with junk in the unused control bits, so a wrong digest length or a leaking bit shows up. It checks that a soft reset empties the queue and clears the status, and that it also drops the configured state. A design that skipped either would report a false write error or leave stale words to read. It also checks that the interrupt follows only enabled bits, arrives one cycle late and stays high until cleared, and that a partial clear removes only the bits in its mask.

// File: rtl/dgst_pkg.sv
package dgst_pkg;

  localparam logic [7:0] OFS_RESET  = 8'h00;
  localparam logic [7:0] OFS_LEN_HI = 8'h04;
  localparam logic [7:0] OFS_LEN_LO = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_ENABLE = 8'h14;
  localparam logic [7:0] OFS_CLEAR  = 8'h18;
  localparam logic [7:0] OFS_QUEUE  = 8'h1C;
  localparam logic [7:0] OFS_ID0    = 8'h40;
  localparam logic [7:0] OFS_ID1    = 8'h50;
  localparam logic [7:0] OFS_ID2    = 8'h60;
  localparam logic [7:0] OFS_ID3    = 8'h70;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RESET, SEL_LEN_HI, SEL_LEN_LO, SEL_CTRL, SEL_STATUS,
    SEL_ENABLE, SEL_QUEUE, SEL_ID0, SEL_ID1, SEL_ID2, SEL_ID3
  } rd_sel_e;

  // Strobes handed from the decoder to the datapath
  typedef struct packed {
    logic    wrReset;
    logic    wrLenHi;
    logic    wrLenLo;
    logic    wrCtrl;
    logic    wrEnable;
    logic    wrClear;
    logic    rdAny;
    logic    rdQueue;
    rd_sel_e rdSel;
  } dgst_strobe_t;

  function automatic logic [3:0] wordsForAlgo(input logic [1:0] algo);
    case (algo)
      2'd0:    return 4'd4;
      2'd1:    return 4'd5;
      2'd2:    return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dgst_ctrl.sv
module dgst_ctrl
  import dgst_pkg::*;
(
  input  logic [7:0]   busAddr,
  input  logic         busWe,
  input  logic         busRe,
  output dgst_strobe_t strobes
);

  rd_sel_e sel;

  always_comb begin
    case (busAddr)
      OFS_RESET:  sel = SEL_RESET;
      OFS_LEN_HI: sel = SEL_LEN_HI;
      OFS_LEN_LO: sel = SEL_LEN_LO;
      OFS_CTRL:   sel = SEL_CTRL;
      OFS_STATUS: sel = SEL_STATUS;
      OFS_ENABLE: sel = SEL_ENABLE;
      OFS_QUEUE:  sel = SEL_QUEUE;
      OFS_ID0:    sel = SEL_ID0;
      OFS_ID1:    sel = SEL_ID1;
      OFS_ID2:    sel = SEL_ID2;
      OFS_ID3:    sel = SEL_ID3;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes.wrReset  = busWe && (busAddr == OFS_RESET);
    strobes.wrLenHi  = busWe && (busAddr == OFS_LEN_HI);
    strobes.wrLenLo  = busWe && (busAddr == OFS_LEN_LO);
    strobes.wrCtrl   = busWe && (busAddr == OFS_CTRL);
    strobes.wrEnable = busWe && (busAddr == OFS_ENABLE);
    strobes.wrClear  = busWe && (busAddr == OFS_CLEAR);
    strobes.rdAny    = busRe;
    strobes.rdQueue  = busRe && (busAddr == OFS_QUEUE);
    strobes.rdSel    = sel;
  end

endmodule

// File: rtl/dgst_datapath.sv
module dgst_datapath
  import dgst_pkg::*;
#(
  parameter int          QDEPTH   = 8,
  parameter logic [31:0] ID_WORD0 = 32'h4447_0001,
  parameter logic [31:0] ID_WORD1 = 32'h0000_0102,
  parameter logic [31:0] ID_WORD2 = 32'h0000_000F,
  parameter logic [31:0] ID_WORD3 = 32'h0000_0008
) (
  input  logic         clk,
  input  logic         rstN,
  input  dgst_strobe_t strobes,
  input  logic [31:0]  busWdata,
  input  logic         coreWordValid,
  input  logic [31:0]  coreWord,
  input  logic         coreDone,
  input  logic         dataWordSeen,
  output logic [31:0]  busRdata,
  output logic         configured,
  output logic         engineReset,
  output logic [1:0]   cfgAlgo,
  output logic [1:0]   cfgByteOrder,
  output logic [63:0]  msgLenBits,
  output logic [3:0]   statusBits,
  output logic [3:0]   enableBits,
  output logic [$clog2(QDEPTH+1)-1:0] qCount,
  output logic         irq
);

  localparam int PTRW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNTW = $clog2(QDEPTH + 1);

  logic [31:0]     lenHi, lenLo;
  logic [31:0]     qMem [QDEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic            softClr, pushEn, popEn, emptyRead, pending;
  logic [3:0]      setMask, clrMask;
  logic [31:0]     rdMux;

  assign softClr   = engineReset;
  assign pushEn    = coreWordValid && !softClr && (qCount < CNTW'(QDEPTH));
  assign popEn     = strobes.rdQueue && (qCount != '0);
  assign emptyRead = strobes.rdQueue && (qCount == '0);
  assign setMask   = {dataWordSeen && !configured, emptyRead, coreDone, pushEn};
  assign clrMask   = strobes.wrClear ? busWdata[3:0] : 4'h0;
  assign pending   = |(statusBits & enableBits);
  assign msgLenBits = {lenHi, lenLo};

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenHi        <= '0;
      lenLo        <= '0;
      cfgAlgo      <= '0;
      cfgByteOrder <= '0;
      enableBits   <= '0;
      engineReset  <= 1'b0;
      configured   <= 1'b0;
    end else begin
      if (strobes.wrLenHi)  lenHi <= busWdata;
      if (strobes.wrLenLo)  lenLo <= busWdata;
      if (strobes.wrEnable) enableBits <= busWdata[3:0];
      if (strobes.wrReset)  engineReset <= busWdata[0];
      if (strobes.wrCtrl) begin
        cfgAlgo      <= busWdata[1:0];
        cfgByteOrder <= busWdata[9:8];
      end
      if (softClr)                     configured <= 1'b0;
      else if (strobes.wrCtrl)         configured <= 1'b1;
    end
  end

  // Interrupt status and request
  always_ff @(posedge clk) begin
    if (!rstN || softClr) begin
      statusBits <= '0;
      irq        <= 1'b0;
    end else begin
      statusBits <= (statusBits & ~clrMask) | setMask;
      irq        <= pending;
    end
  end

  // Result queue
  always_ff @(posedge clk) begin
    if (pushEn) qMem[wrPtr] <= coreWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN || softClr) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (pushEn) wrPtr <= (wrPtr == PTRW'(QDEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (popEn)  rdPtr <= (rdPtr == PTRW'(QDEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // Read multiplexer
  always_comb begin
    case (strobes.rdSel)
      SEL_RESET:  rdMux = {31'b0, engineReset};
      SEL_LEN_HI: rdMux = lenHi;
      SEL_LEN_LO: rdMux = lenLo;
      SEL_CTRL:   rdMux = {22'b0, cfgByteOrder, 6'b0, cfgAlgo};
      SEL_STATUS: rdMux = {23'b0, pending, 4'b0, statusBits};
      SEL_ENABLE: rdMux = {28'b0, enableBits};
      SEL_QUEUE:  rdMux = (qCount != '0) ? qMem[rdPtr] : 32'h0;
      SEL_ID0:    rdMux = ID_WORD0;
      SEL_ID1:    rdMux = ID_WORD1;
      SEL_ID2:    rdMux = ID_WORD2;
      SEL_ID3:    rdMux = ID_WORD3;
      default:    rdMux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busRdata <= '0;
    else if (strobes.rdAny) busRdata <= rdMux;
  end

endmodule

// File: rtl/digest_reg_frontend.sv
module digest_reg_frontend
  import dgst_pkg::*;
#(
  parameter int          QDEPTH   = 8,
  parameter logic [31:0] ID_WORD0 = 32'h4447_0001,
  parameter logic [31:0] ID_WORD1 = 32'h0000_0102,
  parameter logic [31:0] ID_WORD2 = 32'h0000_000F,
  parameter logic [31:0] ID_WORD3 = 32'h0000_0008
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        coreWordValid,
  input  logic [31:0] coreWord,
  input  logic        coreDone,
  input  logic        dataWordSeen,
  output logic        configured,
  output logic        engineReset,
  output logic [1:0]  cfgAlgo,
  output logic [1:0]  cfgByteOrder,
  output logic [63:0] msgLenBits,
  output logic [3:0]  digestWords,
  output logic        irq
);

  localparam int CNTW = $clog2(QDEPTH + 1);

  dgst_strobe_t    strobes;
  logic [3:0]      statusBits, enableBits;
  logic [CNTW-1:0] qCount;

  dgst_ctrl ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strobes (strobes)
  );

  dgst_datapath #(
    .QDEPTH   (QDEPTH),
    .ID_WORD0 (ID_WORD0),
    .ID_WORD1 (ID_WORD1),
    .ID_WORD2 (ID_WORD2),
    .ID_WORD3 (ID_WORD3)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .busWdata      (busWdata),
    .coreWordValid (coreWordValid),
    .coreWord      (coreWord),
    .coreDone      (coreDone),
    .dataWordSeen  (dataWordSeen),
    .busRdata      (busRdata),
    .configured    (configured),
    .engineReset   (engineReset),
    .cfgAlgo       (cfgAlgo),
    .cfgByteOrder  (cfgByteOrder),
    .msgLenBits    (msgLenBits),
    .statusBits    (statusBits),
    .enableBits    (enableBits),
    .qCount        (qCount),
    .irq           (irq)
  );

  assign digestWords = wordsForAlgo(cfgAlgo);

endmodule

// File: rtl/dgst_checker.sv
module dgst_checker #(
  parameter int QDEPTH = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [7:0]                  busAddr,
  input logic                        busWe,
  input logic                        busRe,
  input logic [31:0]                 busRdata,
  input logic                        configured,
  input logic                        engineReset,
  input logic [3:0]                  digestWords,
  input logic [3:0]                  statusBits,
  input logic [3:0]                  enableBits,
  input logic [$clog2(QDEPTH+1)-1:0] qCount,
  input logic                        irq
);

  assert_reset_drops_config_R4: assert property (@(posedge clk) disable iff (!rstN)
    engineReset |=> !configured);

  assert_ctrl_sets_config_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 8'h0C && !engineReset) |=> configured);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 8'h1C && qCount == '0 && !engineReset) |=> (busRdata == 32'h0 && statusBits[2]));

  assert_irq_rises_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((|(statusBits & enableBits)) && !engineReset) |=> irq);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusBits & enableBits)) |=> !irq);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= ($clog2(QDEPTH+1))'(QDEPTH));

  assert_word_count_R13: assert property (@(posedge clk) disable iff (!rstN)
    digestWords inside {4'd4, 4'd5, 4'd7, 4'd8});

endmodule

bind digest_reg_frontend dgst_checker #(.QDEPTH(QDEPTH)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busRe       (busRe),
  .busRdata    (busRdata),
  .configured  (configured),
  .engineReset (engineReset),
  .digestWords (digestWords),
  .statusBits  (statusBits),
  .enableBits  (enableBits),
  .qCount      (qCount),
  .irq         (irq)
);

// File: tb/digest_reg_frontend_tb_top.sv
module digest_reg_frontend_tb_top;

  localparam int QD = 8;
  localparam logic [31:0] ID0 = 32'h4447_0001, ID1 = 32'h0000_0102,
                          ID2 = 32'h0000_000F, ID3 = 32'h0000_0008;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic        coreWordValid = 1'b0, coreDone = 1'b0, dataWordSeen = 1'b0;
  logic [31:0] coreWord = '0;
  logic        configured, engineReset, irq;
  logic [1:0]  cfgAlgo, cfgByteOrder;
  logic [63:0] msgLenBits;
  logic [3:0]  digestWords;

  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  digest_reg_frontend dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .coreWordValid(coreWordValid),
    .coreWord(coreWord), .coreDone(coreDone), .dataWordSeen(dataWordSeen),
    .configured(configured), .engineReset(engineReset), .cfgAlgo(cfgAlgo),
    .cfgByteOrder(cfgByteOrder), .msgLenBits(msgLenBits),
    .digestWords(digestWords), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRe = 1'b1;
    @(negedge clk); busRe = 1'b0; d = busRdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic pulseReset();
    busWrite(8'h00, 32'h1); idle(); busWrite(8'h00, 32'h0);
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk); coreWord = w; coreWordValid = 1'b1;
    @(negedge clk); coreWordValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); coreDone = 1'b1;
    @(negedge clk); coreDone = 1'b0;
  endtask

  task automatic pulseData();
    @(negedge clk); dataWordSeen = 1'b1;
    @(negedge clk); dataWordSeen = 1'b0;
  endtask

  function automatic logic [3:0] expWords(input int a);
    int t[4] = '{4, 5, 7, 8};
    return 4'(t[a]);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();

    // R1 reset state
    check(!irq && !engineReset && !configured, "R1 outputs", {irq, engineReset, configured}, 0);
    check(msgLenBits == 64'h0, "R1 length", msgLenBits, 0);
    busRead(8'h10, rd); check(rd == 0, "R1 status", rd, 0);
    busRead(8'h0C, rd); check(rd == 0, "R1 control", rd, 0);

    // R12 identification words, writes ignored, unmapped reads zero
    for (int k = 0; k < 2; k++) begin
      busRead(8'h40, rd); check(rd == ID0, "R12 id0", rd, ID0);
      busRead(8'h50, rd); check(rd == ID1, "R12 id1", rd, ID1);
      busRead(8'h60, rd); check(rd == ID2, "R12 id2", rd, ID2);
      busRead(8'h70, rd); check(rd == ID3, "R12 id3", rd, ID3);
      busWrite(8'h40, 32'hFFFF_FFFF); busWrite(8'h70, 32'h0);
    end
    busRead(8'h24, rd); check(rd == 0, "R12 unmapped", rd, 0);
    busRead(8'h18, rd); check(rd == 0, "R12 clear reads zero", rd, 0);

    // R2 length registers
    for (int k = 0; k < 6; k++) begin
      logic [31:0] hi, lo;
      hi = 32'h1 << (k * 5);
      lo = 32'hA5A5_0000 ^ (32'h1357 * k);
      busWrite(8'h04, hi); busWrite(8'h08, lo);
      busRead(8'h04, rd); check(rd == hi, "R2 high", rd, hi);
      busRead(8'h08, rd); check(rd == lo, "R2 low", rd, lo);
      check(msgLenBits == {hi, lo}, "R2 output", msgLenBits, {hi, lo});
    end

    // R3 / R13 control sweep with junk in unused bits
    for (int a = 0; a < 4; a++) begin
      for (int o = 0; o < 4; o++) begin
        logic [31:0] w, e;
        w = 32'hFFFF_FCFC | (32'(o) << 8) | 32'(a);
        e = (32'(o) << 8) | 32'(a);
        busWrite(8'h0C, w);
        busRead(8'h0C, rd); check(rd == e, "R3 control readback", rd, e);
        check(cfgAlgo == 2'(a) && cfgByteOrder == 2'(o), "R3 fields", {cfgByteOrder, cfgAlgo}, {o[1:0], a[1:0]});
        check(configured, "R3 configured", configured, 1);
        check(digestWords == expWords(a), "R13 words", digestWords, expWords(a));
      end
    end

    // R7 write error before configuration only
    pulseReset();
    check(!configured, "R4 reset drops config", configured, 0);
    pulseData();
    busRead(8'h10, rd); check(rd[3:0] == 4'b1000, "R7 early data error", rd, 32'h8);
    busWrite(8'h18, 32'hF);
    busWrite(8'h0C, 32'h3);
    pulseData();
    busRead(8'h10, rd); check(rd[3:0] == 4'b0000, "R7 configured data ok", rd, 0);

    // R5 / R6 / R8 queue at every fill level
    for (int n = 0; n <= QD; n++) begin
      pulseReset();
      busWrite(8'h0C, 32'h3);
      for (int i = 0; i < n; i++) pushWord(32'hC0DE_0000 + 32'(n * 16 + i));
      pulseDone();
      busRead(8'h10, rd);
      check(rd[3:0] == {2'b00, 1'b1, n > 0}, "R8 status bits", rd, {30'b0, 1'b1, n > 0});
      for (int i = 0; i < n; i++) begin
        busRead(8'h1C, rd);
        check(rd == 32'hC0DE_0000 + 32'(n * 16 + i), "R5 order", rd, 32'hC0DE_0000 + 32'(n * 16 + i));
      end
      busRead(8'h1C, rd); check(rd == 0, "R6 empty read zero", rd, 0);
      busRead(8'h10, rd); check(rd[2], "R6 read error bit", rd, 32'h4);
      pushWord(32'hBEEF_0000 + 32'(n));
      busRead(8'h1C, rd); check(rd == 32'hBEEF_0000 + 32'(n), "R6 no underflow", rd, 32'hBEEF_0000 + 32'(n));
    end

    // R5 overflow: extra words dropped
    pulseReset();
    for (int i = 0; i <= QD; i++) pushWord(32'(i + 1));
    for (int i = 0; i < QD; i++) begin
      busRead(8'h1C, rd); check(rd == 32'(i + 1), "R5 full order", rd, i + 1);
    end
    busRead(8'h1C, rd); check(rd == 0, "R5 drop beyond depth", rd, 0);

    // R9 partial clear
    pulseReset();
    pulseData(); pushWord(32'h1); pulseDone();
    busRead(8'h10, rd); check(rd[3:0] == 4'b1011, "R9 set", rd, 32'hB);
    busWrite(8'h18, 32'h2);
    busRead(8'h10, rd); check(rd[3:0] == 4'b1001, "R9 partial clear", rd, 32'h9);
    busWrite(8'h18, 32'hF);
    busRead(8'h10, rd); check(rd[3:0] == 4'b0000, "R9 full clear", rd, 0);

    // R10 / R11 interrupt masking and hold
    busWrite(8'h14, 32'h2);
    busRead(8'h14, rd); check(rd == 32'h2, "R10 enable readback", rd, 2);
    pushWord(32'h7);
    idle(); check(!irq, "R10 masked bit no irq", irq, 0);
    busRead(8'h10, rd); check(rd[8] == 1'b0, "R11 bit8 clear", rd, 0);
    pulseDone();
    check(!irq, "R10 registered delay", irq, 0);
    idle(); check(irq, "R10 irq raised", irq, 1);
    repeat (5) idle();
    check(irq, "R10 irq held", irq, 1);
    busRead(8'h10, rd); check(rd[8] && rd[1], "R11 bit8 set", rd, 32'h103);
    busWrite(8'h18, 32'h1);
    idle(); check(irq, "R10 unrelated clear keeps irq", irq, 1);
    busWrite(8'h18, 32'h2);
    idle(); check(!irq, "R10 irq cleared", irq, 0);

    // R4 soft reset clears queue and status, keeps length and enable
    busWrite(8'h04, 32'h1234); busWrite(8'h0C, 32'h1);
    pushWord(32'hAA); pulseDone();
    busWrite(8'h00, 32'h1); idle();
    check(engineReset && !configured, "R4 held", {engineReset, configured}, 2);
    busRead(8'h10, rd); check(rd == 0, "R4 status cleared", rd, 0);
    pushWord(32'hBB);
    busWrite(8'h0C, 32'h2);
    check(!configured, "R4 ctrl blocked in reset", configured, 0);
    busRead(8'h00, rd); check(rd == 1, "R4 reset readback", rd, 1);
    busWrite(8'h00, 32'h0);
    check(!engineReset, "R4 released", engineReset, 0);
    busRead(8'h1C, rd); check(rd == 0, "R4 queue emptied", rd, 0);
    busRead(8'h04, rd); check(rd == 32'h1234, "R4 length kept", rd, 32'h1234);
    busRead(8'h14, rd); check(rd == 32'h2, "R4 enable kept", rd, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule